// File: doc/BRIEF.md
# Folded 9/7 Wavelet Analysis Filter

This block performs a single level of the one-dimensional biorthogonal 9/7 wavelet analysis on a continuous stream of 12-bit signed samples. It accepts one sample on every clock edge, with no handshake. It produces a stream in which approximation (low-pass) and detail (high-pass) coefficients alternate. Each sub-band is therefore decimated by two, and the block as a whole still delivers one coefficient per clock.

Both filters are symmetric. A nine-entry delay line feeds pre-adders that fold mirror-image samples into five pair sums. One bank of multiplier-less shift-add networks then scales those sums. A registered select picks the low-pass constants on cycles where the newest sample has an even index and the high-pass constants on odd cycles. Two adder levels and a rounding stage complete the result. Every register-to-register path holds at most one constant multiply and two additions.

The block does not extend the signal at its start. Its output is simply marked invalid until the delay line has been filled after reset.

Top module: `dwt97_fold`

## Requirements
- R1: With x[n] the n-th sample captured since reset (n from 0) and c = n−4, an even n yields the approximation value 154·x[c] + 68·(x[c−1]+x[c+1]) − 20·(x[c−2]+x[c+2]) − 4·(x[c−3]+x[c+3]) + 7·(x[c−4]+x[c+4]), before the scaling of R3.
- R2: An odd n yields the detail value 285·x[c] − 151·(x[c−1]+x[c+1]) − 15·(x[c−2]+x[c+2]) + 23·(x[c−3]+x[c+3]), before the scaling of R3. The outermost pair does not contribute.
- R3: The integer sum S from R1 or R2 is output as floor((S + 128) / 256), which rounds halves toward positive infinity. The result is clamped to the 16-bit signed range.
- R4: out_is_high is 0 for an approximation value (even n) and 1 for a detail value (odd n). It therefore alternates on every valid cycle.
- R5: The result for sample x[n] appears on the outputs after the fourth rising edge that follows the edge capturing x[n]. A new result arrives on every clock.
- R6: out_valid is 0 during reset and stays 0 until x[8] has been captured. The first valid result is the approximation value for n = 8. Without a further reset, out_valid then stays 1.
- R7: Asserting rst_n low forces out_valid to 0 at once, without waiting for a clock edge. After release, sample numbering restarts at n = 0 and R6 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 12 | Signed input sample, captured on every rising edge |
| out_valid | output | 1 | High when out_coef holds a result |
| out_is_high | output | 1 | 0 = approximation coefficient, 1 = detail coefficient |
| out_coef | output | 16 | Signed rounded coefficient |

## Verification
An all-zero stream shows that nothing leaks from reset values. A single isolated impulse walks across the window, so each tap's constant and its place in the pair folding show up separately in both phases. Constant full-scale positive and negative streams expose the DC gains and the rounding of negative sums, and an alternating full-scale stream drives the detail filter near its largest magnitude. Small random values around zero exercise rounding ties, and wide random values then check general bit-exact agreement, including the restart of numbering after a reset taken in the middle of a stream.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;
  // Symmetric pair count of the longer filter (centre plus four mirror pairs)
  localparam int NPAIR  = 5;
  localparam int TAPS   = 2 * NPAIR - 1;
  // Coefficient magnitude bits for the shift-add networks
  localparam int CMAG_W = 10;
  // Register stages from the capture edge to the output register
  localparam int LAT    = 4;
  // Quantized to 1/256, centre tap first, then outward
  localparam int LP_K [NPAIR] = '{154, 68, -20, -4, 7};
  localparam int HP_K [NPAIR] = '{285, -151, -15, 23, 0};
endpackage

// File: rtl/dwt97_window.sv
module dwt97_window #(
  parameter int IN_W = 12,
  parameter int TAPS = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] din,
  output logic signed [IN_W-1:0] tap_o [TAPS],
  output logic                   full_o,
  output logic                   odd_o
);
  localparam int CW = $clog2(TAPS + 1);

  logic signed [IN_W-1:0] tap_q [TAPS];
  logic signed [IN_W-1:0] tap_d [TAPS];
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   odd_q, odd_d;

  always_comb begin
    tap_d[0] = din;
    for (int i = 1; i < TAPS; i++) tap_d[i] = tap_q[i-1];
    cnt_d = (cnt_q == CW'(TAPS)) ? cnt_q : cnt_q + 1'b1;
    odd_d = ~odd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
      cnt_q <= '0;
      odd_q <= 1'b1;
    end else begin
      tap_q <= tap_d;
      cnt_q <= cnt_d;
      odd_q <= odd_d;
    end
  end

  assign tap_o  = tap_q;
  assign full_o = (cnt_q == CW'(TAPS));
  assign odd_o  = odd_q;
endmodule

// File: rtl/dwt97_pre.sv
module dwt97_pre #(
  parameter int IN_W = 12,
  parameter int TAPS = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] tap_i [TAPS],
  input  logic                   full_i,
  input  logic                   odd_i,
  output logic signed [IN_W:0]   pair_o [(TAPS+1)/2],
  output logic                   vld_o,
  output logic                   hi_o
);
  localparam int NP = (TAPS + 1) / 2;
  localparam int C  = TAPS / 2;

  logic signed [IN_W:0] pair_q [NP];
  logic signed [IN_W:0] pair_d [NP];
  logic                 vld_q, hi_q;

  always_comb begin
    pair_d[0] = {tap_i[C][IN_W-1], tap_i[C]};
    for (int j = 1; j < NP; j++)
      pair_d[j] = {tap_i[C-j][IN_W-1], tap_i[C-j]} + {tap_i[C+j][IN_W-1], tap_i[C+j]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NP; j++) pair_q[j] <= '0;
      vld_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      pair_q <= pair_d;
      vld_q  <= full_i;
      hi_q   <= odd_i;
    end
  end

  assign pair_o = pair_q;
  assign vld_o  = vld_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/dwt97_cmul.sv
module dwt97_cmul
  import dwt97_pkg::*;
#(
  parameter int AW = 13,
  parameter int PW = 24,
  parameter int NP = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [AW-1:0] pair_i [NP],
  input  logic                 vld_i,
  input  logic                 hi_i,
  output logic signed [PW-1:0] prod_o [NP],
  output logic                 vld_o,
  output logic                 hi_o
);
  logic signed [PW-1:0] prod_d [NP];
  logic signed [PW-1:0] prod_q [NP];
  logic                 vld_q, hi_q;

  // Multiplier-less scaling by a constant: one shifted term per set bit
  function automatic logic signed [PW-1:0] shadd(input logic signed [AW-1:0] a, input int k);
    logic signed [PW-1:0] ext;
    logic signed [PW-1:0] acc;
    int                   m;
    ext = {{(PW-AW){a[AW-1]}}, a};
    acc = '0;
    m   = (k < 0) ? -k : k;
    for (int b = 0; b < CMAG_W; b++)
      if (m[b]) acc = acc + (ext <<< b);
    return (k < 0) ? -acc : acc;
  endfunction

  for (genvar j = 0; j < NP; j++) begin : g_tap
    logic signed [PW-1:0] lo_p, hi_p;
    assign lo_p      = shadd(pair_i[j], LP_K[j]);
    assign hi_p      = shadd(pair_i[j], HP_K[j]);
    assign prod_d[j] = hi_i ? hi_p : lo_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NP; j++) prod_q[j] <= '0;
      vld_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      prod_q <= prod_d;
      vld_q  <= vld_i;
      hi_q   <= hi_i;
    end
  end

  assign prod_o = prod_q;
  assign vld_o  = vld_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/dwt97_accum.sv
module dwt97_accum #(
  parameter int PW    = 24,
  parameter int NP    = 5,
  parameter int OUT_W = 16,
  parameter int FRAC  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PW-1:0]    prod_i [NP],
  input  logic                    vld_i,
  input  logic                    hi_i,
  output logic signed [OUT_W-1:0] res_o,
  output logic                    vld_o,
  output logic                    hi_o
);
  localparam int SW = PW + $clog2(NP) + 1;
  localparam int NA = (NP + 1) / 2;
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (FRAC - 1));
  localparam logic signed [SW-1:0] MAXV = SW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [SW-1:0]    part_a_d, part_b_d, part_a_q, part_b_q;
  logic signed [SW-1:0]    tot, shr;
  logic signed [OUT_W-1:0] res_d, res_q;
  logic                    vld_c_q, hi_c_q, vld_q, hi_q;

  // Stage C: two partial sums, each at most two adder levels deep
  always_comb begin
    part_a_d = '0;
    part_b_d = '0;
    for (int j = 0; j < NP; j++) begin
      if (j < NA) part_a_d = part_a_d + {{(SW-PW){prod_i[j][PW-1]}}, prod_i[j]};
      else        part_b_d = part_b_d + {{(SW-PW){prod_i[j][PW-1]}}, prod_i[j]};
    end
  end

  // Stage D: final add, round half up, clamp
  always_comb begin
    tot = part_a_q + part_b_q + HALF;
    shr = tot >>> FRAC;
    if (shr > MAXV)      res_d = MAXV[OUT_W-1:0];
    else if (shr < MINV) res_d = MINV[OUT_W-1:0];
    else                 res_d = shr[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_a_q <= '0;
      part_b_q <= '0;
      vld_c_q  <= 1'b0;
      hi_c_q   <= 1'b0;
      res_q    <= '0;
      vld_q    <= 1'b0;
      hi_q     <= 1'b0;
    end else begin
      part_a_q <= part_a_d;
      part_b_q <= part_b_d;
      vld_c_q  <= vld_i;
      hi_c_q   <= hi_i;
      res_q    <= res_d;
      vld_q    <= vld_c_q;
      hi_q     <= hi_c_q;
    end
  end

  assign res_o = res_q;
  assign vld_o = vld_q;
  assign hi_o  = hi_q;
endmodule

// File: rtl/dwt97_fold.sv
module dwt97_fold
  import dwt97_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16,
  parameter int FRAC  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [IN_W-1:0]  sample_in,
  output logic                    out_valid,
  output logic                    out_is_high,
  output logic signed [OUT_W-1:0] out_coef
);
  localparam int NP = NPAIR;
  localparam int AW = IN_W + 1;
  localparam int PW = AW + CMAG_W + 1;

  logic signed [IN_W-1:0] tap [TAPS];
  logic                   full, odd;
  logic signed [AW-1:0]   pair [NP];
  logic                   pre_vld, pre_hi;
  logic signed [PW-1:0]   prod [NP];
  logic                   mul_vld, mul_hi;

  dwt97_window #(.IN_W(IN_W), .TAPS(TAPS)) u_window (
    .clk(clk), .rst_n(rst_n), .din(sample_in),
    .tap_o(tap), .full_o(full), .odd_o(odd)
  );

  dwt97_pre #(.IN_W(IN_W), .TAPS(TAPS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tap_i(tap), .full_i(full), .odd_i(odd),
    .pair_o(pair), .vld_o(pre_vld), .hi_o(pre_hi)
  );

  dwt97_cmul #(.AW(AW), .PW(PW), .NP(NP)) u_cmul (
    .clk(clk), .rst_n(rst_n), .pair_i(pair), .vld_i(pre_vld), .hi_i(pre_hi),
    .prod_o(prod), .vld_o(mul_vld), .hi_o(mul_hi)
  );

  dwt97_accum #(.PW(PW), .NP(NP), .OUT_W(OUT_W), .FRAC(FRAC)) u_accum (
    .clk(clk), .rst_n(rst_n), .prod_i(prod), .vld_i(mul_vld), .hi_i(mul_hi),
    .res_o(out_coef), .vld_o(out_valid), .hi_o(out_is_high)
  );
endmodule

// File: rtl/dwt97_fold_chk.sv
module dwt97_fold_chk
  import dwt97_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic signed [IN_W-1:0]  sample_in,
  input logic                    out_valid,
  input logic                    out_is_high,
  input logic signed [OUT_W-1:0] out_coef
);
  localparam int FILL = TAPS + LAT;
  localparam int CW   = $clog2(FILL + 1);

  logic [CW-1:0] fill_q, zrun_q;
  logic          past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      zrun_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (fill_q != CW'(FILL)) fill_q <= fill_q + 1'b1;
      if (sample_in != '0)          zrun_q <= '0;
      else if (zrun_q != CW'(FILL)) zrun_q <= zrun_q + 1'b1;
    end
  end

  a_r6_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fill_q == CW'(FILL)));

  a_r6_valid_once_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == CW'(FILL)) |-> out_valid);

  a_r6_first_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(out_valid)) |-> !out_is_high);

  a_r4_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(out_valid) && out_valid) |-> (out_is_high != $past(out_is_high)));

  a_r1_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    ((zrun_q == CW'(FILL)) && out_valid) |-> (out_coef == '0));
endmodule

bind dwt97_fold dwt97_fold_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
  .out_valid(out_valid), .out_is_high(out_is_high), .out_coef(out_coef)
);

// File: tb/dwt97_fold_tb.sv
`timescale 1ns/1ps
module dwt97_fold_tb;
  logic               clk;
  logic               rst_n;
  logic signed [11:0] sample_in;
  logic               out_valid;
  logic               out_is_high;
  logic signed [15:0] out_coef;

  int checks;
  int errors;
  bit done;
  int hist [0:1023];

  dwt97_fold u_dut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
    .out_valid(out_valid), .out_is_high(out_is_high), .out_coef(out_coef)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference for R1, R2, R3 written from the requirement text
  function automatic int model(input int n);
    int lp [5] = '{154, 68, -20, -4, 7};
    int hp [5] = '{285, -151, -15, 23, 0};
    int c = n - 4;
    int s;
    int r;
    if (n % 2 == 0) begin
      s = lp[0] * hist[c];
      for (int j = 1; j < 5; j++) s += lp[j] * (hist[c-j] + hist[c+j]);
    end else begin
      s = hp[0] * hist[c];
      for (int j = 1; j < 5; j++) s += hp[j] * (hist[c-j] + hist[c+j]);
    end
    r = (s + 128) >>> 8;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int gen(input int kind, input int k);
    case (kind)
      0: return 0;
      1: return (k == 20) ? 1000 : 0;
      2: return 2047;
      3: return -2048;
      4: return (k % 2 == 0) ? 2047 : -2048;
      5: return int'($urandom_range(6)) - 3;
      default: return int'($urandom_range(4095)) - 2048;
    endcase
  endfunction

  task automatic run_seg(input int kind, input int len, input bit first, input string tag);
    for (int k = 0; k < len + 4; k++) hist[k] = gen(kind, k);
    if (!first) begin
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(out_valid == 1'b0, "R7 async clear", int'(out_valid), 0);
    end
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R6 reset state", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int k = 0; k < len + 4; k++) begin
      sample_in = 12'(hist[k]);
      @(negedge clk);
      if (k >= 4) begin
        if (k - 4 < 8) begin
          check(out_valid == 1'b0, "R6 fill", int'(out_valid), 0);
        end else begin
          check(out_valid == 1'b1, "R6 valid", int'(out_valid), 1);
          check(out_is_high == ((k - 4) % 2 == 1), "R4 flag", int'(out_is_high), (k - 4) % 2);
          if ((k - 4) % 2 == 0)
            check(int'(out_coef) == model(k - 4), {"R1 R3 R5 ", tag}, int'(out_coef), model(k - 4));
          else
            check(int'(out_coef) == model(k - 4), {"R2 R3 R5 ", tag}, int'(out_coef), model(k - 4));
        end
      end else begin
        check(out_valid == 1'b0, "R6 pipeline fill", int'(out_valid), 0);
      end
    end
  endtask

  initial begin
    int seed;
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    sample_in = '0;
    seed      = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    run_seg(0, 40, 1'b1, "zeros");
    run_seg(1, 40, 1'b0, "impulse");
    run_seg(2, 30, 1'b0, "max const");
    run_seg(3, 30, 1'b0, "min const");
    run_seg(4, 40, 1'b0, "alternating");
    run_seg(5, 200, 1'b0, "near zero");
    run_seg(6, 600, 1'b0, "random");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog: got no finish expected finish at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule